// File: doc/BRIEF.md
# Peripheral Register Access Sequencer

This block carries out one register read or one register write on a byte-wide peripheral for each upstream request. A request names the register space (command or data), the direction, the channel (A or B) and, for writes, a data byte. The sequencer packs these into a single access word and presents it to the peripheral with a one-cycle output strobe. It then polls the peripheral status word until the busy flag in its top bit drops.

When the peripheral is finished, the sequencer reports completion with a single-cycle done pulse. For reads, it returns the low byte of the status word it sampled at that point. A separate acknowledge access sends a word with only the acknowledge flag set, and it returns data the same way a read does. If the busy flag never clears, a poll limit set by a parameter ends the access with an error flag.

Top module: `pacc_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A request is taken at a clock edge where `req_valid` and `req_ready` are both high.
- R2: The access word is formed as follows. Bit 8 is set for the data space (clear for the command space). Bit 9 is set for a read. Bit 10 is set for channel B. Bits 7:0 carry the write byte for a write and are zero for a read. All other bits are zero.
- R3: An acknowledge access produces a word with only bit 11 set, ignores the space, direction, channel and data fields, and returns data like a read.
- R4: `bus_strobe` is high for exactly one cycle, in the cycle after the request is taken. `bus_word` carries the access word in that cycle and is zero in every other cycle.
- R5: The status input is first sampled two cycles after the strobe cycle, so one idle cycle separates the strobe from the first sample.
- R6: An access completes at the first sample in which status bit 8 (busy) is zero. `rsp_done` is high for exactly the following cycle, and `req_ready` returns in the cycle after that.
- R7: When a read or acknowledge access completes, `rsp_rdata` takes status bits 7:0 from the completing sample. It holds that value through later writes and timeouts until the next successful read.
- R8: If POLL_MAX consecutive samples show busy, the access ends. `rsp_done` rises in the next cycle with `rsp_err` high. `rsp_err` is low on every successful completion.
- R9: After reset, `req_ready` is high, and `bus_strobe`, `bus_word`, `rsp_done`, `rsp_err` and `rsp_rdata` are zero.
- R10: `req_valid` held high during an access starts no further access until the sequencer is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_is_data | input | 1 | 1 = data space, 0 = command space |
| req_is_read | input | 1 | 1 = read, 0 = write |
| req_chan_b | input | 1 | 1 = channel B, 0 = channel A |
| req_ack | input | 1 | Acknowledge access |
| req_wdata | input | DATA_W | Write byte |
| rsp_rdata | output | DATA_W | Byte returned by the last successful read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Poll limit reached, valid with done |
| bus_word | output | WORD_W | Access word to the peripheral |
| bus_strobe | output | 1 | Output-word strobe |
| bus_status | input | DATA_W+1 | Peripheral status, top bit busy |

## Verification
The bench builds the sequencer with POLL_MAX set to 4 and the default widths. With that limit, the timeout path and the exact boundary case (three busy samples followed by a clear one) complete within a few cycles. The peripheral model drives the busy flag from a per-access pattern indexed by cycles since the strobe. A pattern that clears busy only in the gap cycle exposes a sampling position that is off by one. A reference model compares every output on every clock across writes, reads, acknowledges, held requests and timeouts.

// File: rtl/pacc_pkg.sv
// Package: shared state type of the access sequencer.
// Assumes: nothing beyond SystemVerilog 2017.
package pacc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEND = 3'd1,
        ST_GAP  = 3'd2,
        ST_POLL = 3'd3,
        ST_FIN  = 3'd4
    } pacc_state_t;
endpackage

// File: rtl/pacc_word.sv
// Module: forms the access word from the request fields.
// Assumes: WORD_W >= DATA_W + 4. Flag bits sit directly above the data byte.
module pacc_word #(
    parameter int DATA_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              is_data_i,
    input  logic              is_read_i,
    input  logic              chan_b_i,
    input  logic              ack_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [WORD_W-1:0] word_o
);
    localparam int SEL_BIT = DATA_W;
    localparam int RD_BIT  = DATA_W + 1;
    localparam int CHB_BIT = DATA_W + 2;
    localparam int ACK_BIT = DATA_W + 3;

    // Merge flag bits and (for writes) the data byte into one word
    always_comb begin
        word_o = '0;
        if (ack_i) begin
            word_o[ACK_BIT] = 1'b1;
        end else begin
            word_o[SEL_BIT] = is_data_i;
            word_o[RD_BIT]  = is_read_i;
            word_o[CHB_BIT] = chan_b_i;
            if (!is_read_i)
                word_o[DATA_W-1:0] = wdata_i;
        end
    end
endmodule

// File: rtl/pacc_poll.sv
// Module: counts busy status samples and flags success or expiry.
// Assumes: clr_i is pulsed before the first sample of each access.
module pacc_poll #(
    parameter int POLL_MAX = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic sample_i,
    input  logic busy_i,
    output logic ok_o,
    output logic expire_o
);
    localparam int CNT_W = $clog2(POLL_MAX + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_MAX - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count consecutive busy samples of the current access
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (sample_i && busy_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // Classify the current sample
    always_comb begin
        ok_o     = sample_i && !busy_i;
        expire_o = sample_i && busy_i && (cnt_q == LAST);
    end
endmodule

// File: rtl/pacc_seq.sv
// Module: top of the access sequencer. Takes one request when idle,
// strobes the access word, waits one cycle, polls busy, then pulses done.
// Assumes: the bus_status top bit is the busy flag. Low DATA_W bits are read data.
module pacc_seq #(
    parameter int DATA_W   = 8,
    parameter int WORD_W   = 16,
    parameter int POLL_MAX = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_data,
    input  logic              req_is_read,
    input  logic              req_chan_b,
    input  logic              req_ack,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [WORD_W-1:0] bus_word,
    output logic              bus_strobe,
    input  logic [DATA_W:0]   bus_status
);
    import pacc_pkg::*;

    localparam int BUSY_BIT = DATA_W;

    pacc_state_t       state_q, state_d;
    logic [WORD_W-1:0] word_new, word_q;
    logic              rd_q, err_q;
    logic [DATA_W-1:0] rdata_q;
    logic              poll_clr, poll_sample, poll_ok, poll_expire;

    pacc_word #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_word (
        .is_data_i (req_is_data),
        .is_read_i (req_is_read),
        .chan_b_i  (req_chan_b),
        .ack_i     (req_ack),
        .wdata_i   (req_wdata),
        .word_o    (word_new)
    );

    pacc_poll #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (poll_clr),
        .sample_i (poll_sample),
        .busy_i   (bus_status[BUSY_BIT]),
        .ok_o     (poll_ok),
        .expire_o (poll_expire)
    );

    // Next-state selection for the access sequence
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_SEND;
            ST_SEND: state_d = ST_GAP;
            ST_GAP:  state_d = ST_POLL;
            ST_POLL: if (poll_ok || poll_expire) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State, latched request and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            rd_q    <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                word_q <= word_new;
                rd_q   <= req_is_read || req_ack;
            end
            if (poll_ok || poll_expire)
                err_q <= poll_expire;
            if (poll_ok && rd_q)
                rdata_q <= bus_status[DATA_W-1:0];
        end
    end

    // Port and poll-control decode from state
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        bus_strobe  = (state_q == ST_SEND);
        bus_word    = (state_q == ST_SEND) ? word_q : '0;
        poll_clr    = (state_q == ST_GAP);
        poll_sample = (state_q == ST_POLL);
        rsp_done    = (state_q == ST_FIN);
        rsp_err     = (state_q == ST_FIN) && err_q;
        rsp_rdata   = rdata_q;
    end

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> !bus_strobe);
    // R4
    accept_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bus_strobe);
    // R5
    gap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> !poll_sample);
    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));
    // R8
    expire_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_expire |=> (rsp_done && rsp_err));
    // R8
    ok_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_ok |=> (rsp_done && !rsp_err));
endmodule

// File: tb/sim_pacc_seq.sv
// Bench: behavioural reference model compared against every output on every clock.
module sim_pacc_seq;
    localparam int DW = 8;
    localparam int WW = 16;
    localparam int PM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_data = 1'b0, req_is_read = 1'b0;
    logic req_chan_b = 1'b0, req_ack = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_done, rsp_err, bus_strobe;
    logic [DW-1:0] rsp_rdata;
    logic [WW-1:0] bus_word;
    logic [DW:0] bus_status = '0;

    int n_chk = 0, n_err = 0, cyc = 0;
    string tag = "R9";

    pacc_seq #(.DATA_W(DW), .WORD_W(WW), .POLL_MAX(PM)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_data(req_is_data), .req_is_read(req_is_read),
        .req_chan_b(req_chan_b), .req_ack(req_ack), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .bus_word(bus_word), .bus_strobe(bus_strobe), .bus_status(bus_status));

    always #10 clk = ~clk;

    // Reference model state
    int m_phase = 0, m_cnt = 0;
    bit m_rd = 0, m_err = 0;
    logic [WW-1:0] m_word = '0;
    logic [DW-1:0] m_rdata = '0;

    function automatic logic [WW-1:0] exp_word(bit d, bit r, bit b, bit a, logic [DW-1:0] w);
        logic [WW-1:0] x = '0;
        if (a) x[11] = 1'b1;
        else begin
            x[8] = d; x[9] = r; x[10] = b;
            if (!r) x[7:0] = w;
        end
        return x;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase <= 0; m_rdata <= '0; m_err <= 0; m_cnt <= 0;
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                    m_phase <= 1;
                    m_word <= exp_word(req_is_data, req_is_read, req_chan_b, req_ack, req_wdata);
                    m_rd <= req_is_read || req_ack;
                end
                1: m_phase <= 2;
                2: begin m_phase <= 3; m_cnt <= 0; end
                3: if (!bus_status[DW]) begin
                    m_phase <= 4; m_err <= 0;
                    if (m_rd) m_rdata <= bus_status[DW-1:0];
                end else if (m_cnt == PM - 1) begin
                    m_phase <= 4; m_err <= 1;
                end else m_cnt <= m_cnt + 1;
                default: m_phase <= 0;
            endcase
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s (%s) t=%0t actual=%h expected=%h", req, tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1", 32'(req_ready), 32'(m_phase == 0));
            chk("R4", 32'(bus_strobe), 32'(m_phase == 1));
            chk("R2", 32'(bus_word), 32'(m_phase == 1 ? m_word : '0));
            chk("R6", 32'(rsp_done), 32'(m_phase == 4));
            chk("R8", 32'(rsp_err), 32'(m_phase == 4 && m_err));
            chk("R7", 32'(rsp_rdata), 32'(m_rdata));
        end
    end

    // Peripheral: busy pattern indexed by cycles since strobe
    logic [31:0] pat = '0;
    logic [DW-1:0] sbyte = '0;
    int since = -1;
    always @(posedge clk) begin
        #1;
        if (bus_strobe) since = 0;
        else if (since >= 0) since++;
        bus_status[DW-1:0] = sbyte;
        bus_status[DW] = (since >= 0 && since < 32) ? pat[since] : 1'b0;
    end

    task automatic access(string t, bit d, bit r, bit b, bit a, logic [DW-1:0] w,
                          logic [31:0] p, logic [DW-1:0] s, bit hold);
        tag = t; pat = p; sbyte = s;
        @(posedge clk); #2;
        req_valid = 1; req_is_data = d; req_is_read = r; req_chan_b = b;
        req_ack = a; req_wdata = w;
        @(posedge clk); #2;
        if (hold) begin req_wdata = ~w; req_chan_b = ~b; end
        else req_valid = 0;
        do @(negedge clk); while (!rsp_done);
        @(posedge clk); #2;
        req_valid = 0;
        since = -1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        // R9 reset state
        chk("R9", 32'(req_ready), 32'd1);
        chk("R9", 32'(bus_strobe), 32'd0);
        chk("R9", 32'(bus_word), 32'd0);
        chk("R9", 32'({rsp_done, rsp_err}), 32'd0);
        chk("R9", 32'(rsp_rdata), 32'd0);
        access("R2 cmd write A", 0, 0, 0, 0, 8'hA5, 32'h7, 8'h11, 0);
        access("R2 data write B", 1, 0, 1, 0, 8'h3C, 32'h3, 8'h22, 0);
        access("R7 cmd read B", 0, 1, 1, 0, 8'hFF, 32'h1F, 8'h3C, 0);
        access("R6 data read A no busy", 1, 1, 0, 0, 8'h00, 32'h0, 8'h5A, 0);
        access("R3 ack", 1, 0, 1, 1, 8'hEE, 32'h7, 8'h81, 0);
        access("R5 gap clear", 1, 1, 1, 0, 8'h00, 32'h1D, 8'h66, 0);
        access("R8 boundary success", 0, 1, 0, 0, 8'h00, 32'h1F, 8'h77, 0);
        access("R8 timeout", 0, 1, 0, 0, 8'h00, 32'hFFFFFFFF, 8'h99, 0);
        access("R7 hold after write", 1, 0, 0, 0, 8'h42, 32'h0, 8'hCC, 0);
        access("R10 held valid", 0, 0, 1, 0, 8'h18, 32'h7, 8'h00, 1);
        access("R10 next after hold", 1, 1, 1, 0, 8'h00, 32'h3, 8'hD2, 0);
        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog (%s) actual=hung expected=finished", tag);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule